// File: doc/BRIEF.md
# VGA Sync and Pixel Address Generator

This block produces the raster timing for a 640 x 480 screen refreshed at about 60 Hz from a 25 MHz pixel clock. A horizontal counter runs on every pixel clock and covers an 800-clock line. A vertical counter advances once per horizontal sync pulse and covers a 521-line frame. Decoding the two counters gives the active-low horizontal and vertical sync strobes and a display-active flag.

Both counters are phased to start at zero on the first visible pixel of the first visible row. During the visible area the counts are therefore the pixel column and the row directly. The block also presents the linear video memory address `row * 640 + column`. A colour source or a frame buffer reader placed downstream can use the column, row and address as they are. Every output is registered on the pixel clock. All timing lengths are parameters, and the defaults give the 640 x 480 mode.

Top module: `vga_scan_gen`

## Requirements
- R1: In a clock edge taken with `rst` high, every output goes to its idle value: `hsync_n`=1, `vsync_n`=1, `active`=0, `col`=0, `row`=0 and `addr`=0. At the first edge after `rst` falls, the outputs show column 0 and row 0 with `active`=1.
- R2: `col` rises by one per clock through 0..799, then returns to 0. A line is 800 clocks long.
- R3: `hsync_n` is low exactly while `col` is in 656..751, which is 96 clocks per line, and high otherwise.
- R4: `row` increases by one in the same clock in which `col` steps from 655 to 656, which is the onset of HS. It wraps from 520 to 0, giving 521 lines per frame, and keeps its value at every other clock.
- R5: `vsync_n` is low exactly while `row` is 490 or 491, and high otherwise.
- R6: `active` is 1 exactly when `col` < 640 and `row` < 480.
- R7: `addr` equals `row*640 + col` while `active` is 1, and 0 while `active` is 0.
- R8: A reset raised in the middle of a frame returns all outputs to the R1 idle values at the next edge. After release, the scan restarts from column 0, row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | High while inside the visible area |
| col | output | 10 | Horizontal count, equal to the pixel column while visible |
| row | output | 10 | Vertical count, equal to the row while visible |
| addr | output | 19 | Linear video memory address, 0 outside the visible area |

## Verification
The vertical sync window and the 520-to-0 row wrap are the hardest events to reach from the ports. At the default geometry, the row reaches 490 only after almost 400,000 clocks. The bench therefore runs a second copy of the block with a reduced geometry (25-clock lines, 13-line frames) and takes it through several whole frames. Against the same model it also checks the default copy over its first lines. The model derives the expected column, row, sync and address from the elapsed clock count alone. A reset in the middle of a frame shows that the scan restarts from the origin.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  typedef enum logic [1:0] {
    PH_DISP  = 2'd0,
    PH_FRONT = 2'd1,
    PH_SYNC  = 2'd2,
    PH_BACK  = 2'd3
  } scan_phase_e;

  // Classify a count into display, front porch, sync or back porch.
  function automatic scan_phase_e phase_of(input int unsigned c,
                                           input int unsigned disp,
                                           input int unsigned front,
                                           input int unsigned sync);
    if (c < disp)                      return PH_DISP;
    else if (c < disp + front)         return PH_FRONT;
    else if (c < disp + front + sync)  return PH_SYNC;
    else                               return PH_BACK;
  endfunction

endpackage

// File: rtl/vga_axis_counter.sv
module vga_axis_counter
  import vga_scan_pkg::*;
#(
  parameter int DISP  = 640,
  parameter int FRONT = 16,
  parameter int SYNC  = 96,
  parameter int BACK  = 48,
  localparam int TOTAL = DISP + FRONT + SYNC + BACK,
  localparam int CW    = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [CW-1:0] count,
  output scan_phase_e   phase,
  output logic          sync_start
);

  localparam logic [CW-1:0] LAST     = CW'(TOTAL - 1);
  localparam logic [CW-1:0] PRE_SYNC = CW'(DISP + FRONT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (step) begin
      if (count == LAST) count <= '0;
      else               count <= count + 1'b1;
    end
  end

  always_comb begin
    phase      = phase_of(32'(count), DISP, FRONT, SYNC);
    sync_start = step && (count == PRE_SYNC);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= LAST);                                                  // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && count != LAST) |=> (count == $past(count) + 1'b1));     // R4
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && count == LAST) |=> (count == '0));                      // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count));                                       // R4

endmodule

// File: rtl/vga_scan_out.sv
module vga_scan_out
  import vga_scan_pkg::*;
#(
  parameter int HW     = 10,
  parameter int VW     = 10,
  parameter int ADDR_W = 19,
  parameter int H_DISP = 640
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HW-1:0]     h_cnt,
  input  logic [VW-1:0]     v_cnt,
  input  scan_phase_e       h_phase,
  input  scan_phase_e       v_phase,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              active,
  output logic [HW-1:0]     col,
  output logic [VW-1:0]     row,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LINE_STRIDE = ADDR_W'(H_DISP);

  logic              vis_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    vis_d  = (h_phase == PH_DISP) && (v_phase == PH_DISP);
    addr_d = vis_d ? (ADDR_W'(v_cnt) * LINE_STRIDE + ADDR_W'(h_cnt)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      active  <= 1'b0;
      col     <= '0;
      row     <= '0;
      addr    <= '0;
    end else begin
      hsync_n <= (h_phase != PH_SYNC);
      vsync_n <= (v_phase != PH_SYNC);
      active  <= vis_d;
      col     <= h_cnt;
      row     <= v_cnt;
      addr    <= addr_d;
    end
  end

  AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active |-> (addr == '0));                                       // R7
  AST_SYNC_BLANK: assert property (@(posedge clk) disable iff (rst)
    (!hsync_n || !vsync_n) |-> !active);                             // R6
  AST_HS_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |=> !hsync_n);                                    // R3
  AST_ACTIVE_COL: assert property (@(posedge clk) disable iff (rst)
    active |-> (col < HW'(H_DISP)));                                 // R6

endmodule

// File: rtl/vga_scan_gen.sv
module vga_scan_gen
  import vga_scan_pkg::*;
#(
  parameter int H_DISP  = 640,
  parameter int H_FRONT = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int V_DISP  = 480,
  parameter int V_FRONT = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 29,
  localparam int HW     = $clog2(H_DISP + H_FRONT + H_SYNC + H_BACK),
  localparam int VW     = $clog2(V_DISP + V_FRONT + V_SYNC + V_BACK),
  localparam int ADDR_W = $clog2(H_DISP * V_DISP)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              active,
  output logic [HW-1:0]     col,
  output logic [VW-1:0]     row,
  output logic [ADDR_W-1:0] addr
);

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  scan_phase_e   h_phase;
  scan_phase_e   v_phase;
  logic          h_sync_start;
  logic          v_sync_start;

  vga_axis_counter #(
    .DISP(H_DISP), .FRONT(H_FRONT), .SYNC(H_SYNC), .BACK(H_BACK)
  ) u_hcnt (
    .clk(clk), .rst(rst), .step(1'b1),
    .count(h_cnt), .phase(h_phase), .sync_start(h_sync_start)
  );

  // Rows advance at the onset of each horizontal sync pulse.
  vga_axis_counter #(
    .DISP(V_DISP), .FRONT(V_FRONT), .SYNC(V_SYNC), .BACK(V_BACK)
  ) u_vcnt (
    .clk(clk), .rst(rst), .step(h_sync_start),
    .count(v_cnt), .phase(v_phase), .sync_start(v_sync_start)
  );

  vga_scan_out #(
    .HW(HW), .VW(VW), .ADDR_W(ADDR_W), .H_DISP(H_DISP)
  ) u_out (
    .clk(clk), .rst(rst),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .h_phase(h_phase), .v_phase(v_phase),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .active(active),
    .col(col), .row(row), .addr(addr)
  );

  AST_ROW_ON_HS: assert property (@(posedge clk) disable iff (rst)
    (row != $past(row)) |-> $fell(hsync_n));                         // R4
  AST_VS_AT_HS: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> $fell(hsync_n));                              // R5

endmodule

// File: tb/vga_scan_gen_tb.sv
module vga_scan_gen_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // Default geometry
  logic        f_hs, f_vs, f_act;
  logic [9:0]  f_col, f_row;
  logic [18:0] f_addr;
  // Reduced geometry: 16+2+4+3 clocks, 6+2+2+3 lines
  logic        s_hs, s_vs, s_act;
  logic [4:0]  s_col;
  logic [3:0]  s_row;
  logic [6:0]  s_addr;

  vga_scan_gen u_dut (
    .clk(clk), .rst(rst), .hsync_n(f_hs), .vsync_n(f_vs), .active(f_act),
    .col(f_col), .row(f_row), .addr(f_addr)
  );

  vga_scan_gen #(
    .H_DISP(16), .H_FRONT(2), .H_SYNC(4), .H_BACK(3),
    .V_DISP(6), .V_FRONT(2), .V_SYNC(2), .V_BACK(3)
  ) u_small (
    .clk(clk), .rst(rst), .hsync_n(s_hs), .vsync_n(s_vs), .active(s_act),
    .col(s_col), .row(s_row), .addr(s_addr)
  );

  int total = 0;
  int bad   = 0;
  int edges = 0;
  string idle_tag = "R1";

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (edges=%0d)", req, what, act, exp, edges);
    end
  endtask

  task automatic check_inst(input string nm,
                            input int hd, input int hf, input int hsw, input int hb,
                            input int vd, input int vf, input int vsw, input int vb,
                            input logic hs, input logic vs, input logic ac,
                            input int c, input int r, input int a);
    int ht, vt, t, h, v, e_hs, e_vs, e_act, e_addr;
    if (edges == 0) begin
      chk(idle_tag, {nm, " hsync_n idle"}, int'(hs), 1);
      chk(idle_tag, {nm, " vsync_n idle"}, int'(vs), 1);
      chk(idle_tag, {nm, " active idle"},  int'(ac), 0);
      chk(idle_tag, {nm, " col idle"},  c, 0);
      chk(idle_tag, {nm, " row idle"},  r, 0);
      chk(idle_tag, {nm, " addr idle"}, a, 0);
    end else begin
      ht = hd + hf + hsw + hb;
      vt = vd + vf + vsw + vb;
      t  = edges - 1;
      h  = t % ht;
      v  = (t / ht + ((h >= hd + hf) ? 1 : 0)) % vt;
      e_hs   = (h >= hd + hf && h < hd + hf + hsw) ? 0 : 1;
      e_vs   = (v >= vd + vf && v < vd + vf + vsw) ? 0 : 1;
      e_act  = (h < hd && v < vd) ? 1 : 0;
      e_addr = e_act ? v * hd + h : 0;
      chk("R2", {nm, " col"}, c, h);
      chk("R4", {nm, " row"}, r, v);
      chk("R3", {nm, " hsync_n"}, int'(hs), e_hs);
      chk("R5", {nm, " vsync_n"}, int'(vs), e_vs);
      chk("R6", {nm, " active"}, int'(ac), e_act);
      chk("R7", {nm, " addr"}, a, e_addr);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_inst("default", 640, 16, 96, 48, 480, 10, 2, 29,
               f_hs, f_vs, f_act, int'(f_col), int'(f_row), int'(f_addr));
    check_inst("small", 16, 2, 4, 3, 6, 2, 2, 3,
               s_hs, s_vs, s_act, int'(s_col), int'(s_row), int'(s_addr));
  endtask

  // R1: idle outputs while reset is held
  task automatic t_reset_state();
    idle_tag = "R1";
    rst = 1'b1;
    for (int i = 0; i < 3; i++) tick();
  endtask

  // R1 R2 R3 R6 R7: first lines of the default geometry, first visible pixel
  task automatic t_first_lines();
    rst = 1'b0;
    tick();
    chk("R1", "default first pixel active", int'(f_act), 1);
    for (int i = 0; i < 3 * 800 + 20; i++) tick();
  endtask

  // R4 R5: several full frames of the reduced geometry, row wrap included
  task automatic t_small_frames();
    for (int i = 0; i < 3 * 325 + 40; i++) tick();
  endtask

  // R8: reset in the middle of a frame, then restart from the origin
  task automatic t_midrun_reset();
    idle_tag = "R8";
    rst = 1'b1;
    for (int i = 0; i < 2; i++) tick();
    rst = 1'b0;
    tick();
    chk("R8", "restart col", int'(f_col), 0);
    chk("R8", "restart row", int'(s_row), 0);
    for (int i = 0; i < 900; i++) tick();
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_first_lines();
    t_small_frames();
    t_midrun_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule